// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Transmit Store

This block holds transmit data for one USB IN endpoint in two equal packet layers. A local CPU writes bytes into one layer (the fill layer) and closes it by pulsing a packet-ready strobe. It can then start on the other layer while the first is drained on the bus. The USB side starts a transfer with an IN-token strobe and reads bytes out one per `usb_rd_en`. It then ends the transfer in one of two ways: `usb_ack` means the host took the packet, and `usb_abort` means no handshake came back, so the packet must be sent again.

Each layer runs its own small state machine with four states. `LY_EMPTY` holds no data. `LY_FILL` is being written by the CPU. `LY_READY` is closed and waiting for a token. `LY_SEND` is being drained. The transitions are:
- `LY_EMPTY→LY_FILL` on the first accepted byte.
- `LY_EMPTY/LY_FILL→LY_READY` on an accepted packet-ready strobe.
- `LY_READY→LY_SEND` on a token.
- `LY_SEND→LY_EMPTY` on ack.
- `LY_SEND→LY_READY` on abort.

Two selector bits choose the layers. The fill selector flips when a packet is closed, and the transmit selector flips when a packet is acknowledged, so packets leave in the order they were closed. A separate interrupt machine has two states. It stays in `IQ_RUN` normally. It enters `IQ_MASK` for `DROP_CYC` cycles after each accepted packet-ready strobe, and returns to `IQ_RUN` when that count runs out.

Top module: `inep_pingpong_buf`

## Requirements
- R1: An accepted byte write lands in the fill layer at the next free position. The fill layer accepts bytes while it is in `LY_EMPTY` or `LY_FILL` and holds fewer than DEPTH (64) bytes. Writes beyond that are ignored, so a packet is never longer than DEPTH.
- R2: A packet-ready strobe is accepted only when the fill layer is `LY_EMPTY` or `LY_FILL`. A byte written in the same cycle is included in the packet. The closed layer becomes `LY_READY`, and the fill selector moves to the other layer. A strobe that is not accepted changes nothing.
- R3: A token while the transmit layer is `LY_READY` starts sending it from byte 0. From the next cycle, `usb_tx_active` is 1, `usb_tx_len` gives the packet length, and `usb_rd_data` shows the current byte. Each `usb_rd_en` advances one byte, in the order the bytes were written.
- R4: `usb_ack` while sending empties that layer. The other layer becomes the transmit layer, so the next token sends the packet that was closed second.
- R5: `usb_abort` while sending returns the layer to `LY_READY` with its data kept. The next token resends the packet from byte 0. `usb_ack` takes priority over `usb_abort`.
- R6: `pkt_rdy_stat` is 1 exactly when the fill layer is neither `LY_EMPTY` nor `LY_FILL`, which means both layers hold closed packets.
- R7: `irq` is 1 exactly when `irq_en` is 1, the fill layer is free, and the interrupt machine is in `IQ_RUN`.
- R8: Each accepted packet-ready strobe holds `irq` low for exactly DROP_CYC (default 3, at most 6) cycles. A new accepted strobe restarts that count.
- R9: A token when the transmit layer is `LY_EMPTY` or `LY_FILL` raises `usb_no_data` for the following cycle and leaves all layer state unchanged.
- R10: After reset, both layers are `LY_EMPTY`, both selectors point to layer 0, and the interrupt machine is in `IQ_RUN`. The outputs are then `pkt_rdy_stat`=0, `usb_tx_active`=0, `usb_no_data`=0, and `irq` equal to `irq_en`.
- R11: A token that arrives while a packet is already sending rewinds it to byte 0 without changing layers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | Byte write strobe into the fill layer |
| cpu_wr_data | input | DW | Byte to write |
| cpu_pkt_rdy_set | input | 1 | Close the fill layer as a packet |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Transmit-ready interrupt: a layer is free for writing |
| pkt_rdy_stat | output | 1 | Status bit: no layer is free |
| usb_in_tok | input | 1 | IN token received |
| usb_rd_en | input | 1 | Advance to the next byte of the sending packet |
| usb_rd_data | output | DW | Current byte of the sending packet |
| usb_ack | input | 1 | Host acknowledged the sending packet |
| usb_abort | input | 1 | Transfer failed, packet is to be resent |
| usb_tx_active | output | 1 | A packet is being sent |
| usb_tx_len | output | $clog2(DEPTH+1) | Length of the sending packet |
| usb_no_data | output | 1 | The last token found no closed packet |

## Verification
If a layer state or a selector goes wrong, it shows at the ports within one cycle. `pkt_rdy_stat` and `irq` are decoded directly from the fill layer's state. `usb_tx_active` and `usb_no_data` follow from the transmit layer's state on the next token. If a selector points at the wrong layer, the packets come out in the wrong order, and `usb_rd_data` shows it on the first byte read after the token. A broken write position or read pointer shows as a wrong byte or length as soon as that packet is drained. A miscounted interrupt mask shows as `irq` returning one cycle early or late after a packet-ready strobe.

// File: rtl/inep_pkg.sv
package inep_pkg;
    typedef enum logic [1:0] {
        LY_EMPTY = 2'd0,
        LY_FILL  = 2'd1,
        LY_READY = 2'd2,
        LY_SEND  = 2'd3
    } layer_st_t;

    typedef enum logic {
        IQ_RUN  = 1'b0,
        IQ_MASK = 1'b1
    } irq_st_t;
endpackage

// File: rtl/inep_layer_ram.sv
module inep_layer_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/inep_layer_fsm.sv
module inep_layer_fsm
    import inep_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int LEN_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_wr,
    input  logic             is_tx,
    input  logic             wr_en,
    input  logic             rdy_set,
    input  logic             in_tok,
    input  logic             rd_en,
    input  logic             ack,
    input  logic             abort,
    output layer_st_t        st,
    output logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] rd_ptr,
    output logic             wr_fire
);
    layer_st_t        st_n;
    logic [LEN_W-1:0] len_n;
    logic [LEN_W-1:0] ptr_n;

    // a byte is taken only by an open layer with room left
    assign wr_fire = is_wr && wr_en && (st == LY_EMPTY || st == LY_FILL)
                     && (len < LEN_W'(DEPTH));

    always_comb begin
        st_n  = st;
        len_n = wr_fire ? len + 1'b1 : len;
        ptr_n = rd_ptr;
        unique case (st)
            LY_EMPTY: begin
                if (is_wr && rdy_set)  st_n = LY_READY;
                else if (wr_fire)      st_n = LY_FILL;
            end
            LY_FILL: begin
                if (is_wr && rdy_set)  st_n = LY_READY;
            end
            LY_READY: begin
                if (is_tx && in_tok) begin
                    st_n  = LY_SEND;
                    ptr_n = '0;
                end
            end
            LY_SEND: begin
                if (is_tx && ack) begin
                    st_n  = LY_EMPTY;
                    len_n = '0;
                    ptr_n = '0;
                end else if (is_tx && abort) begin
                    st_n  = LY_READY;
                    ptr_n = '0;
                end else if (is_tx && in_tok) begin
                    ptr_n = '0;
                end else if (is_tx && rd_en && rd_ptr < len) begin
                    ptr_n = rd_ptr + 1'b1;
                end
            end
            default: st_n = LY_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= LY_EMPTY;
            len    <= '0;
            rd_ptr <= '0;
        end else begin
            st     <= st_n;
            len    <= len_n;
            rd_ptr <= ptr_n;
        end
    end
endmodule

// File: rtl/inep_irq_gen.sv
module inep_irq_gen
    import inep_pkg::*;
#(
    parameter int DROP_CYC = 3,
    localparam int CNT_W   = $clog2(DROP_CYC+1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic free,
    input  logic set_ok,
    output logic irq
);
    irq_st_t          st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            IQ_RUN: begin
                if (set_ok) begin
                    st_n  = IQ_MASK;
                    cnt_n = CNT_W'(DROP_CYC - 1);
                end
            end
            IQ_MASK: begin
                if (set_ok)          cnt_n = CNT_W'(DROP_CYC - 1);
                else if (cnt == '0)  st_n  = IQ_RUN;
                else                 cnt_n = cnt - 1'b1;
            end
            default: st_n = IQ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= IQ_RUN;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    assign irq = irq_en && free && (st == IQ_RUN);
endmodule

// File: rtl/inep_pingpong_buf.sv
module inep_pingpong_buf
    import inep_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DEPTH    = 64,
    parameter int DROP_CYC = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_wr_en,
    input  logic [DW-1:0]              cpu_wr_data,
    input  logic                       cpu_pkt_rdy_set,
    input  logic                       irq_en,
    output logic                       irq,
    output logic                       pkt_rdy_stat,
    input  logic                       usb_in_tok,
    input  logic                       usb_rd_en,
    output logic [DW-1:0]              usb_rd_data,
    input  logic                       usb_ack,
    input  logic                       usb_abort,
    output logic                       usb_tx_active,
    output logic [$clog2(DEPTH+1)-1:0] usb_tx_len,
    output logic                       usb_no_data
);
    localparam int LEN_W  = $clog2(DEPTH+1);
    localparam int AW     = $clog2(DEPTH);
    localparam int LAYERS = 2;

    layer_st_t        st   [LAYERS];
    logic [LEN_W-1:0] len  [LAYERS];
    logic [LEN_W-1:0] rptr [LAYERS];
    logic [DW-1:0]    rdat [LAYERS];
    logic             wfire[LAYERS];

    logic wsel, tsel;
    logic free, set_ok, ack_ok, tok_empty;

    for (genvar g = 0; g < LAYERS; g++) begin : g_layer
        inep_layer_fsm #(.DEPTH(DEPTH)) fsm_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .is_wr   (wsel == 1'(g)),
            .is_tx   (tsel == 1'(g)),
            .wr_en   (cpu_wr_en),
            .rdy_set (cpu_pkt_rdy_set),
            .in_tok  (usb_in_tok),
            .rd_en   (usb_rd_en),
            .ack     (usb_ack),
            .abort   (usb_abort),
            .st      (st[g]),
            .len     (len[g]),
            .rd_ptr  (rptr[g]),
            .wr_fire (wfire[g])
        );

        inep_layer_ram #(.DW(DW), .DEPTH(DEPTH)) ram_i (
            .clk   (clk),
            .we    (wfire[g]),
            .waddr (len[g][AW-1:0]),
            .wdata (cpu_wr_data),
            .raddr (rptr[g][AW-1:0]),
            .rdata (rdat[g])
        );
    end

    assign free      = (st[wsel] == LY_EMPTY) || (st[wsel] == LY_FILL);
    assign set_ok    = cpu_pkt_rdy_set && free;
    assign ack_ok    = usb_ack && (st[tsel] == LY_SEND);
    assign tok_empty = usb_in_tok && ((st[tsel] == LY_EMPTY) || (st[tsel] == LY_FILL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsel        <= 1'b0;
            tsel        <= 1'b0;
            usb_no_data <= 1'b0;
        end else begin
            if (set_ok) wsel <= ~wsel;
            if (ack_ok) tsel <= ~tsel;
            usb_no_data <= tok_empty;
        end
    end

    inep_irq_gen #(.DROP_CYC(DROP_CYC)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_en (irq_en),
        .free   (free),
        .set_ok (set_ok),
        .irq    (irq)
    );

    assign pkt_rdy_stat  = ~free;
    assign usb_tx_active = (st[tsel] == LY_SEND);
    assign usb_tx_len    = len[tsel];
    assign usb_rd_data   = rdat[tsel];
endmodule

// File: rtl/inep_pp_chk.sv
module inep_pp_chk #(
    parameter int DEPTH  = 64,
    localparam int LEN_W = $clog2(DEPTH+1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_en,
    input logic             irq,
    input logic             pkt_rdy_stat,
    input logic             usb_ack,
    input logic             usb_abort,
    input logic             usb_tx_active,
    input logic [LEN_W-1:0] usb_tx_len,
    input logic             usb_no_data
);
    logic [3:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    low_run <= '0;
        else if (irq_en && !pkt_rdy_stat && !irq)      low_run <= (low_run == 4'hF) ? low_run : low_run + 1'b1;
        else                                           low_run <= '0;
    end

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_full_blocks_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rdy_stat |-> !irq);

    assert_irq_returns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= 4'd6);

    assert_len_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        usb_tx_len <= LEN_W'(DEPTH));

    assert_ack_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_ack && usb_tx_active) |=> !usb_tx_active);

    assert_abort_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_abort && usb_tx_active) |=> !usb_tx_active);

    assert_nodata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        usb_no_data |-> !usb_tx_active);
endmodule

bind inep_pingpong_buf inep_pp_chk #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_en        (irq_en),
    .irq           (irq),
    .pkt_rdy_stat  (pkt_rdy_stat),
    .usb_ack       (usb_ack),
    .usb_abort     (usb_abort),
    .usb_tx_active (usb_tx_active),
    .usb_tx_len    (usb_tx_len),
    .usb_no_data   (usb_no_data)
);

// File: tb/inep_pingpong_buf_tb.sv
module inep_pingpong_buf_tb_top;
    localparam int DW    = 8;
    localparam int DEPTH = 64;
    localparam int DROP  = 3;
    localparam int LEN_W = $clog2(DEPTH+1);

    localparam int E = 0, F = 1, RD = 2, S = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 0, setr = 0, en = 0, tok = 0, rd = 0, ack = 0, ab = 0;
    logic [DW-1:0] wd = '0;
    logic irq, stat, txa, nd;
    logic [DW-1:0] rdata;
    logic [LEN_W-1:0] txlen;

    int tests = 0, fails = 0;

    // reference model
    int m_st [2];
    int m_len[2];
    int m_rp [2];
    logic [DW-1:0] m_mem[2][DEPTH];
    int m_wsel, m_tsel, m_mcnt;
    logic m_nd;

    always #10 clk = ~clk;

    inep_pingpong_buf #(.DW(DW), .DEPTH(DEPTH), .DROP_CYC(DROP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(we), .cpu_wr_data(wd), .cpu_pkt_rdy_set(setr),
        .irq_en(en), .irq(irq), .pkt_rdy_stat(stat),
        .usb_in_tok(tok), .usb_rd_en(rd), .usb_rd_data(rdata),
        .usb_ack(ack), .usb_abort(ab),
        .usb_tx_active(txa), .usb_tx_len(txlen), .usb_no_data(nd)
    );

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_free();
        return (m_st[m_wsel] == E) || (m_st[m_wsel] == F);
    endfunction

    function automatic logic exp_irq();
        return en && m_free() && (m_mcnt == 0);
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 2; i++) begin
            m_st[i] = E; m_len[i] = 0; m_rp[i] = 0;
        end
        m_wsel = 0; m_tsel = 0; m_mcnt = 0; m_nd = 0;
    endtask

    task automatic m_edge();
        int ts = m_st[m_tsel];
        int t  = m_tsel;
        bit fr = m_free();
        // CPU side
        if (we && fr && m_len[m_wsel] < DEPTH) begin
            m_mem[m_wsel][m_len[m_wsel]] = wd;
            m_len[m_wsel]++;
            if (m_st[m_wsel] == E) m_st[m_wsel] = F;
        end
        if (setr && fr) begin
            m_st[m_wsel] = RD;
            m_wsel ^= 1;
            m_mcnt = DROP;
        end else if (m_mcnt > 0) begin
            m_mcnt--;
        end
        // USB side, decided on state before the edge
        m_nd = tok && (ts == E || ts == F);
        if (ts == RD && tok) begin
            m_st[t] = S; m_rp[t] = 0;
        end else if (ts == S) begin
            if (ack) begin
                m_st[t] = E; m_len[t] = 0; m_rp[t] = 0; m_tsel ^= 1;
            end else if (ab) begin
                m_st[t] = RD; m_rp[t] = 0;
            end else if (tok) begin
                m_rp[t] = 0;
            end else if (rd && m_rp[t] < m_len[t]) begin
                m_rp[t]++;
            end
        end
    endtask

    task automatic compare();
        chk("R7 irq", int'(irq), int'(exp_irq()));
        chk("R6 pkt_rdy_stat", int'(stat), int'(!m_free()));
        chk("R3 tx_active", int'(txa), int'(m_st[m_tsel] == S));
        chk("R9 no_data", int'(nd), int'(m_nd));
        if (m_st[m_tsel] == S) begin
            chk("R1 tx_len", int'(txlen), m_len[m_tsel]);
            if (m_rp[m_tsel] < m_len[m_tsel])
                chk("R3 rd_data", int'(rdata), int'(m_mem[m_tsel][m_rp[m_tsel]]));
        end
    endtask

    // one clock: apply inputs, update model at the edge, compare at the falling edge
    task automatic cyc(bit w, logic [DW-1:0] d, bit s, bit tk, bit r, bit a, bit b);
        we = w; wd = d; setr = s; tok = tk; rd = r; ack = a; ab = b;
        @(posedge clk);
        #1 m_edge();
        @(negedge clk);
        we = 0; setr = 0; tok = 0; rd = 0; ack = 0; ab = 0;
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_reset();
        en = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 irq", int'(irq), 1);
        chk("R10 stat", int'(stat), 0);
        chk("R10 tx_active", int'(txa), 0);
        chk("R10 no_data", int'(nd), 0);

        // R9: token with nothing closed
        cyc(0, '0, 0, 1, 0, 0, 0);
        chk("R9 no_data pulse", int'(nd), 1);
        // fill layer 0 with 4 bytes, close (R2), irq masked DROP cycles (R8)
        for (int i = 0; i < 4; i++) cyc(1, DW'(8'h10 + i), 0, 0, 0, 0, 0);
        cyc(1, 8'h14, 1, 0, 0, 0, 0);
        for (int i = 0; i < DROP; i++) chk("R8 irq masked", int'(irq), 0);
        for (int i = 0; i < DROP - 1; i++) cyc(0, '0, 0, 0, 0, 0, 0);
        chk("R8 still masked", int'(irq), 0);
        cyc(0, '0, 0, 0, 0, 0, 0);
        chk("R8 irq back", int'(irq), 1);
        // fill layer 1 with 65 writes: one is dropped (R1), close -> both full (R6)
        for (int i = 0; i < DEPTH + 1; i++) cyc(1, DW'(i * 3), 0, 0, 0, 0, 0);
        cyc(0, '0, 1, 0, 0, 0, 0);
        chk("R6 both closed", int'(stat), 1);
        cyc(0, '0, 1, 0, 0, 0, 0);            // R2: refused strobe
        cyc(1, 8'hEE, 0, 0, 0, 0, 0);         // R1: write ignored while full
        // send layer 0, partial read, abort and resend (R5), token rewind (R11)
        cyc(0, '0, 0, 1, 0, 0, 0);
        chk("R3 len 5", int'(txlen), 5);
        cyc(0, '0, 0, 0, 1, 0, 0);
        cyc(0, '0, 0, 0, 1, 0, 0);
        cyc(0, '0, 0, 1, 0, 0, 0);
        chk("R11 rewind", int'(rdata), 8'h10);
        cyc(0, '0, 0, 0, 1, 0, 0);
        cyc(0, '0, 0, 0, 0, 0, 1);
        chk("R5 abort idle", int'(txa), 0);
        cyc(0, '0, 0, 1, 0, 0, 0);
        chk("R5 resend byte0", int'(rdata), 8'h10);
        for (int i = 0; i < 5; i++) cyc(0, '0, 0, 0, 1, 0, 0);
        cyc(0, '0, 0, 0, 0, 1, 0);
        chk("R4 irq after ack", int'(irq), 1);
        cyc(0, '0, 0, 1, 0, 0, 0);
        chk("R4 second packet len", int'(txlen), DEPTH);
        for (int i = 0; i < DEPTH; i++) cyc(0, '0, 0, 0, 1, 0, 0);
        cyc(0, '0, 0, 0, 0, 1, 0);
        idle(2);

        // constrained random traffic
        void'($urandom(32'h1A2B3C4D));
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(99) < 2) en = ~en;
            cyc($urandom_range(99) < 45, DW'($urandom),
                $urandom_range(99) < 6, $urandom_range(99) < 8,
                $urandom_range(99) < 45, $urandom_range(99) < 5,
                $urandom_range(99) < 3);
        end
        en = 1;
        idle(DROP + 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule